// File: doc/BRIEF.md
# Grouped Data Bus Inversion Codec

This block sits between the core logic and a 64-bit active-low host data bus that uses dynamic bus inversion. The bus is cut into four 16-bit lanes, and each lane carries its own inversion flag. On the bus a logical 1 is driven as a low voltage. The transmit path takes a logical word and produces electrical bus levels plus four electrical flag levels. For each lane it chooses whether to invert the lane, so that the lane never drives more than half of its lines low.

The receive path takes electrical bus levels and flags and returns the logical word. It undoes both the active-low convention and any inversion the flag announces. Both paths are combinational. A parameter adds an output register stage, which is on by default. With the register stage on, each path has one cycle of latency and resets to an idle bus with every line high. Lane width and lane count are parameters. This brief describes the default of four lanes of 16 bits.

Top module: `dbi_codec`

## Requirements
- R1: Flag n (bit n of `tx_flag_o` and of `rx_flag_i`) governs data bits [16n+15:16n] only.
- R2: On `tx_bus_o`, no lane ever has more than 8 of its 16 lines at electrical 0.
- R3: In a lane that is not inverted, each `tx_bus_o` line is the complement of its logical bit, so a logical 1 is driven as 0.
- R4: A lane with exactly 8 logical ones is not inverted, and its flag is driven electrical 1 (deasserted).
- R5: A lane with 9 or more logical ones is inverted. Each `tx_bus_o` line then equals its logical bit, and the lane's flag is driven electrical 0 (asserted, active-low).
- R6: When a lane's `rx_flag_i` bit is 1, `rx_data_o` for that lane is the complement of `rx_bus_i`. When the flag bit is 0, `rx_data_o` equals `rx_bus_i`.
- R7: Feeding `tx_bus_o` and `tx_flag_o` back into `rx_bus_i` and `rx_flag_i` returns the original logical word for every input.
- R8: With the register stage on, outputs change one clock after the inputs. While `rst_ni` is low, `tx_bus_o` is all ones, `tx_flag_o` is all ones and `rx_data_o` is zero.
- R9: The inversion decision of a lane does not depend on the contents of any other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | 64 | Logical word to transmit |
| tx_bus_o | output | 64 | Electrical bus levels, 0 = low voltage |
| tx_flag_o | output | 4 | Electrical inversion flags, 0 = lane inverted |
| rx_bus_i | input | 64 | Electrical bus levels received |
| rx_flag_i | input | 4 | Electrical inversion flags received, 0 = lane inverted |
| rx_data_o | output | 64 | Recovered logical word |

## Verification
The timed assertions assume that both input buses carry known values. They also assume the inputs are held stable across each rising edge, because the round-trip and decode properties compare the registered outputs against the input values sampled one edge earlier. To respect this, the stimulus changes inputs only on falling edges. The timed properties do not start until one edge after reset release, so the first comparison never reaches back into the reset period. Flags on the receive side are treated as free inputs, so any pattern of received flags is legal stimulus.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int unsigned LANE_W_DEF = 16;
  localparam int unsigned LANES_DEF  = 4;
  // flag is active-low on the wire
  localparam logic FLAG_ON  = 1'b0;
  localparam logic FLAG_OFF = 1'b1;
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
  import dbi_pkg::*;
#(
  parameter int unsigned W = LANE_W_DEF,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0] data_i,
  output logic [W-1:0] bus_o,
  output logic         flag_o
);
  // logical ones become low lines when not inverted
  logic [CW-1:0] ones;
  logic          flip;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + CW'(data_i[i]);
  end

  // tie at exactly half stays uninverted
  assign flip   = (ones > CW'(W / 2));
  assign bus_o  = flip ? data_i : ~data_i;
  assign flag_o = flip ? FLAG_ON : FLAG_OFF;
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec
  import dbi_pkg::*;
#(
  parameter int unsigned W = LANE_W_DEF
) (
  input  logic [W-1:0] bus_i,
  input  logic         flag_i,
  output logic [W-1:0] data_o
);
  assign data_o = (flag_i == FLAG_ON) ? bus_i : ~bus_i;
endmodule

// File: rtl/dbi_out_stage.sv
module dbi_out_stage #(
  parameter int unsigned W       = 64,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit          EN      = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (EN) begin : g_reg
    logic [W-1:0] q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= RST_VAL;
      else         q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_thru
    assign q_o = d_i;
  end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int unsigned LANE_W  = LANE_W_DEF,
  parameter int unsigned LANES   = LANES_DEF,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned BUS_W  = LANE_W * LANES,
  localparam int unsigned HALF   = LANE_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] tx_data_i,
  output logic [BUS_W-1:0] tx_bus_o,
  output logic [LANES-1:0] tx_flag_o,
  input  logic [BUS_W-1:0] rx_bus_i,
  input  logic [LANES-1:0] rx_flag_i,
  output logic [BUS_W-1:0] rx_data_o
);
  logic [BUS_W-1:0] enc_bus, dec_data;
  logic [LANES-1:0] enc_flag;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dbi_lane_enc #(.W(LANE_W)) u_enc (
      .data_i (tx_data_i[l*LANE_W +: LANE_W]),
      .bus_o  (enc_bus[l*LANE_W +: LANE_W]),
      .flag_o (enc_flag[l])
    );
    dbi_lane_dec #(.W(LANE_W)) u_dec (
      .bus_i  (rx_bus_i[l*LANE_W +: LANE_W]),
      .flag_i (rx_flag_i[l]),
      .data_o (dec_data[l*LANE_W +: LANE_W])
    );
  end

  // idle bus: every line high, no flag asserted
  dbi_out_stage #(.W(BUS_W), .RST_VAL({BUS_W{1'b1}}), .EN(OUT_REG)) u_tx_bus (
    .clk_i, .rst_ni, .d_i(enc_bus), .q_o(tx_bus_o)
  );
  dbi_out_stage #(.W(LANES), .RST_VAL({LANES{FLAG_OFF}}), .EN(OUT_REG)) u_tx_flag (
    .clk_i, .rst_ni, .d_i(enc_flag), .q_o(tx_flag_o)
  );
  dbi_out_stage #(.W(BUS_W), .RST_VAL('0), .EN(OUT_REG)) u_rx_data (
    .clk_i, .rst_ni, .d_i(dec_data), .q_o(rx_data_o)
  );

  // ---------------- assertions ----------------
  logic [BUS_W-1:0] tx_mask, rx_mask;
  logic             past_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign tx_mask[l*LANE_W +: LANE_W] = {LANE_W{tx_flag_o[l] == FLAG_ON}};
    assign rx_mask[l*LANE_W +: LANE_W] = {LANE_W{rx_flag_i[l] == FLAG_ON}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    a_r2_low_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(~tx_bus_o[l*LANE_W +: LANE_W]) <= HALF);
  end

  if (OUT_REG) begin : g_chk_reg
    a_r7_roundtrip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (((~tx_bus_o) ^ tx_mask) == $past(tx_data_i)));
    a_r6_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (rx_data_o == ((~$past(rx_bus_i)) ^ $past(rx_mask))));
    for (genvar l = 0; l < LANES; l++) begin : g_lane_reg
      a_r4_tie_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && ($countones($past(tx_data_i[l*LANE_W +: LANE_W])) == HALF)
        |-> tx_flag_o[l] == FLAG_OFF);
      a_r5_heavy_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && ($countones($past(tx_data_i[l*LANE_W +: LANE_W])) > HALF)
        |-> tx_flag_o[l] == FLAG_ON);
    end
  end else begin : g_chk_comb
    a_r7_roundtrip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((~tx_bus_o) ^ tx_mask) == tx_data_i));
    a_r6_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_data_o == ((~rx_bus_i) ^ rx_mask)));
    for (genvar l = 0; l < LANES; l++) begin : g_lane_comb
      a_r4_tie_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(tx_data_i[l*LANE_W +: LANE_W]) == HALF) |-> tx_flag_o[l] == FLAG_OFF);
      a_r5_heavy_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(tx_data_i[l*LANE_W +: LANE_W]) > HALF) |-> tx_flag_o[l] == FLAG_ON);
    end
  end
endmodule

// File: tb/tb_dbi_codec.sv
`timescale 1ns/1ps
module tb_dbi_codec;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] tx_data_i = '0;
  logic [63:0] tx_bus_o;
  logic [3:0]  tx_flag_o;
  logic [63:0] rx_bus_i = '0;
  logic [3:0]  rx_flag_i = '0;
  logic [63:0] rx_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dbi_codec dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_data_i(tx_data_i), .tx_bus_o(tx_bus_o), .tx_flag_o(tx_flag_o),
    .rx_bus_i(rx_bus_i), .rx_flag_i(rx_flag_i), .rx_data_o(rx_data_o)
  );

  // word, then expected electrical flags (0 = lane inverted)
  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h00FF_00FF_00FF_00FF, 64'h01FF_01FF_01FF_01FF,
    64'h0000_FFFF_00FF_01FF, 64'h01FF_00FF_FFFF_0000,
    64'hFFFF_01FF_0000_00FF, 64'h00FF_0000_01FF_FFFF,
    64'hAAAA_5557_8001_FE7F, 64'hFF00_FF80_5555_0000
  };
  localparam logic [3:0] EXP_FLAG [NV] = '{
    4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b1010,
    4'b0101, 4'b0011, 4'b1100, 4'b1010, 4'b1011
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_enc(input logic [63:0] d, output logic [63:0] bus,
                                    output logic [3:0] flg);
    for (int l = 0; l < 4; l++) begin
      if ($countones(d[l*16 +: 16]) > 8) begin
        bus[l*16 +: 16] = d[l*16 +: 16];
        flg[l] = 1'b0;
      end else begin
        bus[l*16 +: 16] = ~d[l*16 +: 16];
        flg[l] = 1'b1;
      end
    end
  endfunction

  function automatic logic [63:0] model_dec(input logic [63:0] b, input logic [3:0] f);
    logic [63:0] r;
    for (int l = 0; l < 4; l++) r[l*16 +: 16] = f[l] ? ~b[l*16 +: 16] : b[l*16 +: 16];
    return r;
  endfunction

  function automatic logic [63:0] worst_lane_lows(input logic [63:0] b);
    int m = 0;
    for (int l = 0; l < 4; l++)
      if ($countones(~b[l*16 +: 16]) > m) m = $countones(~b[l*16 +: 16]);
    return 64'(m > 8);
  endfunction

  task automatic run_tx(input string req, input logic [63:0] v, input logic [3:0] ef,
                        input bit use_ef);
    logic [63:0] eb;
    logic [3:0]  mf;
    model_enc(v, eb, mf);
    if (!use_ef) ef = mf;
    @(negedge clk) tx_data_i = v;
    @(negedge clk);
    check({req, " R3/R5 bus"}, tx_bus_o, eb);
    check({req, " R1/R4/R5 flags"}, 64'(tx_flag_o), 64'(ef));
    check("R2 low count over limit", worst_lane_lows(tx_bus_o), 64'd0);
    rx_bus_i = tx_bus_o;
    rx_flag_i = tx_flag_o;
    @(negedge clk);
    check("R7 roundtrip", rx_data_o, v);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    // R8 reset state, inputs busy
    tx_data_i = 64'h01FF_01FF_01FF_01FF;
    rx_bus_i  = 64'h1234_5678_9ABC_DEF0;
    rx_flag_i = 4'b0101;
    repeat (3) @(negedge clk);
    check("R8 reset tx_bus", tx_bus_o, {64{1'b1}});
    check("R8 reset tx_flag", 64'(tx_flag_o), 64'hF);
    check("R8 reset rx_data", rx_data_o, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      run_tx((i >= 4) ? "R9 mixed lanes" : "lane pattern", VEC[i], EXP_FLAG[i], 1'b1);

    // R8 latency: output holds until the next rising edge
    @(negedge clk) tx_data_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk) tx_data_i = 64'h0000_0000_0000_0000;
    #1 check("R8 latency hold", tx_bus_o, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk) check("R8 latency update", tx_bus_o, 64'hFFFF_FFFF_FFFF_FFFF ^ 64'hFFFF_FFFF_FFFF_FFFF ^ {64{1'b1}});

    // R6 direct decode, every flag pattern
    for (int f = 0; f < 16; f++) begin
      logic [63:0] b;
      b = {$urandom, $urandom};
      @(negedge clk) begin rx_bus_i = b; rx_flag_i = 4'(f); end
      @(negedge clk) check("R6 decode", rx_data_o, model_dec(b, 4'(f)));
    end

    // R1 single lane: only the touched lane's flag moves
    for (int l = 0; l < 4; l++) begin
      logic [63:0] v;
      logic [3:0]  ef;
      v = '0;
      v[l*16 +: 16] = 16'h01FF;
      ef = 4'hF;
      ef[l] = 1'b0;
      run_tx("R1 lane select", v, ef, 1'b1);
    end

    for (int i = 0; i < 200; i++) run_tx("random", {$urandom, $urandom}, 4'h0, 1'b0);

    finish_up();
  end
endmodule